// File: doc/BRIEF.md
# Storage Device Identify-Response Qualifier

This block watches the 256-word identify response that a storage device returns, presented as a stream of indexed 16-bit words. It decides whether the device may be used for queued DMA transfers. While the words arrive it keeps only the few fields it needs. When the final word (index 255) has been taken it makes the decision in one cycle. Either it accepts the device, or it rejects it with a reason code.

On acceptance the block reports the logical block size, the total block count, the highest Ultra DMA mode the device advertises, and the transfer-mode byte to send in a set-features command, together with that command's opcode and subcommand. A host sequencer pulses `start` before it streams the response and waits for the single-cycle `done` pulse. The results stay valid until the next `start` or `clear`. A packet (removable-media) device is flagged at `start`. It is exempt from the LBA rule and reports a fixed geometry.

Top module: `ata_ident_parser`

## Requirements
- R1: After reset or a `clear` pulse, `busy`, `done` and `accept` are 0, and `reason`, `block_size`, `block_count`, `udma_mode`, `mode_byte`, `sf_opcode` and `sf_subcmd` are all 0.
- R2: A `start` pulse opens a session (`busy`=1) and records `is_packet`. A word is taken only when `word_valid` is high in an open session. The clock edge that takes index 255 closes the session, and `done` is high for exactly the following cycle. Words outside a session are ignored and cause no further `done`. A `clear` in mid-session discards it.
- R3: If bit 8 of word 76 (queued-command support) is clear, the device is rejected with reason 1.
- R4: If word 106 has bits 15:14 equal to 2'b01, and either bit 8 is set or bit 9 is set with bits 3:0 nonzero, the device is rejected with reason 2. Any other value of word 106 passes.
- R5: A non-packet device whose word 49 bit 9 (LBA support) is clear is rejected with reason 3. A packet device skips this rule.
- R6: An accepted non-packet device with word 83 bit 10 clear reports `block_count` = {word 61, word 60}, zero-extended to 64 bits.
- R7: An accepted non-packet device with word 83 bit 10 set reports `block_count` = {word 103, word 102, word 101, word 100}.
- R8: An accepted device reports `block_size` = 512. An accepted packet device reports `block_count` = 0.
- R9: The Ultra DMA mask is bits 6:0 of word 88, and bit 7 and above are ignored. A zero mask rejects the device with reason 4. Otherwise `udma_mode` is the index of the highest set bit of the mask.
- R10: On acceptance `mode_byte` = 8'h40 | `udma_mode`, `sf_opcode` = 8'hEF and `sf_subcmd` = 8'h03.
- R11: The rules are applied in the order R3, R4, R5, R9, and the first one that fails sets `reason`. `accept` = 1 exactly when `reason` = 0. On rejection every numeric result output is 0.
- R12: If a word index is sent more than once in a session, the last value sent is the one used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a new session and wipes captured fields |
| clear | input | 1 | Returns the block to idle and zeroes all results |
| is_packet | input | 1 | Packet-device flag, sampled with `start` |
| word_valid | input | 1 | Word strobe |
| word_idx | input | 8 | Index of the presented word |
| word_data | input | 16 | Value of the presented word |
| busy | output | 1 | Session open |
| done | output | 1 | One-cycle result strobe |
| accept | output | 1 | Device qualified |
| reason | output | 3 | 0 accepted, 1 no queuing, 2 sector size, 3 no LBA, 4 no Ultra DMA |
| block_size | output | 16 | Bytes per block |
| block_count | output | 64 | Total blocks |
| udma_mode | output | 3 | Highest Ultra DMA mode |
| mode_byte | output | 8 | Transfer-mode byte for set-features |
| sf_opcode | output | 8 | Set-features opcode |
| sf_subcmd | output | 8 | Set-features subcommand |

## Verification
The bench targets the cases that are easiest to get wrong.

- **Sector-size word.** It tries bit 9 set with zero low bits, and bit 8 set when bits 15:14 are not 01. A decoder that ignores the qualifier, or that forgets the low-bit test, rejects good devices.
- **Rule priority.** It sends a device that fails the queuing and Ultra DMA rules at once. A wrong priority shows up as the wrong reason code.
- **Ultra DMA mask.** It tries a mask with bit 7 set, a full mask and a single-bit mask. These expose an encoder that picks the lowest bit or lets bit 7 through.
- **Capacity and LBA.** It checks both capacity widths and a packet device without LBA support. A swapped word order or a mis-ordered exemption appears directly in `block_count` and `reason`.
- **Word and session handling.** It sends a duplicated word, traffic after `done`, and a `clear` in mid-stream. These catch capture that fires outside a session.

// File: rtl/ident_pkg.sv
package ident_pkg;

    typedef enum logic [2:0] {
        RSN_OK       = 3'd0,
        RSN_NO_QUEUE = 3'd1,
        RSN_SECTOR   = 3'd2,
        RSN_NO_LBA   = 3'd3,
        RSN_NO_UDMA  = 3'd4
    } reason_e;

    // word indices of interest
    localparam int unsigned IW_LBA    = 49;
    localparam int unsigned IW_CAP28  = 60;   // two words, low first
    localparam int unsigned IW_QUEUE  = 76;
    localparam int unsigned IW_FEAT   = 83;
    localparam int unsigned IW_UDMA   = 88;
    localparam int unsigned IW_CAP48  = 100;  // four words, low first
    localparam int unsigned IW_SECTOR = 106;

    // bit positions inside those words
    localparam int unsigned B_LBA     = 9;
    localparam int unsigned B_QUEUE   = 8;
    localparam int unsigned B_ADDR48  = 10;

    localparam logic [7:0] SF_OPCODE = 8'hEF;
    localparam logic [7:0] SF_XFER   = 8'h03;
    localparam logic [7:0] UDMA_BASE = 8'h40;

endpackage

// File: rtl/ident_capture.sv
module ident_capture
    import ident_pkg::*;
#(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned UDMA_BITS = 7,
    parameter int unsigned C28_WORDS = 2,
    parameter int unsigned C48_WORDS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wipe,
    input  logic                            take,
    input  logic [IDX_W-1:0]                idx,
    input  logic [WORD_W-1:0]               data,
    output logic                            lba_ok,
    output logic                            queue_ok,
    output logic                            addr48,
    output logic [UDMA_BITS-1:0]            udma_mask,
    output logic [1:0]                      sec_kind,
    output logic [1:0]                      sec_flags,
    output logic [3:0]                      sec_ratio,
    output logic [C28_WORDS*WORD_W-1:0]     cap28,
    output logic [C48_WORDS*WORD_W-1:0]     cap48
);

    typedef struct packed {
        logic                               lba;
        logic                               queue;
        logic                               a48;
        logic [UDMA_BITS-1:0]               udma;
        logic [1:0]                         kind;
        logic [1:0]                         flags;
        logic [3:0]                         ratio;
        logic [C28_WORDS-1:0][WORD_W-1:0]   c28;
        logic [C48_WORDS-1:0][WORD_W-1:0]   c48;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (wipe) begin
            cap_d = '0;
        end else if (take) begin
            if (idx == IDX_W'(IW_LBA))    cap_d.lba   = data[B_LBA];
            if (idx == IDX_W'(IW_QUEUE))  cap_d.queue = data[B_QUEUE];
            if (idx == IDX_W'(IW_FEAT))   cap_d.a48   = data[B_ADDR48];
            if (idx == IDX_W'(IW_UDMA))   cap_d.udma  = data[UDMA_BITS-1:0];
            if (idx == IDX_W'(IW_SECTOR)) begin
                cap_d.kind  = data[15:14];
                cap_d.flags = data[9:8];
                cap_d.ratio = data[3:0];
            end
            for (int k = 0; k < C28_WORDS; k++)
                if (idx == IDX_W'(IW_CAP28 + k)) cap_d.c28[k] = data;
            for (int k = 0; k < C48_WORDS; k++)
                if (idx == IDX_W'(IW_CAP48 + k)) cap_d.c48[k] = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign lba_ok    = cap_q.lba;
    assign queue_ok  = cap_q.queue;
    assign addr48    = cap_q.a48;
    assign udma_mask = cap_q.udma;
    assign sec_kind  = cap_q.kind;
    assign sec_flags = cap_q.flags;
    assign sec_ratio = cap_q.ratio;
    assign cap28     = cap_q.c28;
    assign cap48     = cap_q.c48;

    AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (cap28 == '0 && cap48 == '0 && udma_mask == '0)); // R12

endmodule

// File: rtl/ident_udma_pick.sv
module ident_udma_pick #(
    parameter int unsigned N      = 7,
    parameter int unsigned SEL_W  = $clog2(N)
) (
    input  logic [N-1:0]     mask,
    output logic             any,
    output logic [SEL_W-1:0] sel
);

    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (mask[i]) begin
                any = 1'b1;
                sel = SEL_W'(i);
            end
        end
    end

    always_comb begin
        if (any) begin
            AST_UDMA_TOP: assert ((mask >> sel) == N'(1)); // R9
        end
    end

endmodule

// File: rtl/ident_rules.sv
module ident_rules
    import ident_pkg::*;
#(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned UDMA_BITS = 7,
    parameter int unsigned C28_WORDS = 2,
    parameter int unsigned C48_WORDS = 4,
    localparam int unsigned MODE_W   = $clog2(UDMA_BITS),
    localparam int unsigned CAP_W    = C48_WORDS*WORD_W
) (
    input  logic                        pkt,
    input  logic                        lba_ok,
    input  logic                        queue_ok,
    input  logic                        addr48,
    input  logic [UDMA_BITS-1:0]        udma_mask,
    input  logic [1:0]                  sec_kind,
    input  logic [1:0]                  sec_flags,
    input  logic [3:0]                  sec_ratio,
    input  logic [C28_WORDS*WORD_W-1:0] cap28,
    input  logic [CAP_W-1:0]            cap48,
    output reason_e                     reason,
    output logic [CAP_W-1:0]            count,
    output logic [MODE_W-1:0]           mode
);

    logic udma_any;
    logic sec_bad;

    ident_udma_pick #(.N(UDMA_BITS), .SEL_W(MODE_W)) u_pick (
        .mask (udma_mask),
        .any  (udma_any),
        .sel  (mode)
    );

    // sector word only meaningful when its signature field reads 01
    assign sec_bad = (sec_kind == 2'b01) &&
                     (sec_flags[0] || (sec_flags[1] && (sec_ratio != 4'd0)));

    always_comb begin
        if (!queue_ok)            reason = RSN_NO_QUEUE;
        else if (sec_bad)         reason = RSN_SECTOR;
        else if (!pkt && !lba_ok) reason = RSN_NO_LBA;
        else if (!udma_any)       reason = RSN_NO_UDMA;
        else                      reason = RSN_OK;
    end

    always_comb begin
        if (pkt)         count = '0;
        else if (addr48) count = cap48;
        else             count = CAP_W'(cap28);
    end

endmodule

// File: rtl/ata_ident_parser.sv
module ata_ident_parser
    import ident_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned IDX_W       = 8,
    parameter int unsigned LAST_IDX    = 255,
    parameter int unsigned UDMA_BITS   = 7,
    parameter int unsigned BLOCK_BYTES = 512,
    parameter int unsigned SIZE_W      = 16,
    localparam int unsigned C28_WORDS  = 2,
    localparam int unsigned C48_WORDS  = 4,
    localparam int unsigned CAP_W      = C48_WORDS*WORD_W,
    localparam int unsigned MODE_W     = $clog2(UDMA_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              clear,
    input  logic              is_packet,
    input  logic              word_valid,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [WORD_W-1:0] word_data,
    output logic              busy,
    output logic              done,
    output logic              accept,
    output logic [2:0]        reason,
    output logic [SIZE_W-1:0] block_size,
    output logic [CAP_W-1:0]  block_count,
    output logic [MODE_W-1:0] udma_mode,
    output logic [7:0]        mode_byte,
    output logic [7:0]        sf_opcode,
    output logic [7:0]        sf_subcmd
);

    typedef struct packed {
        logic              armed;
        logic              pkt;
        logic              done;
        logic              accept;
        reason_e           reason;
        logic [SIZE_W-1:0] bsize;
        logic [CAP_W-1:0]  count;
        logic [MODE_W-1:0] mode;
        logic [7:0]        mbyte;
        logic [7:0]        op;
        logic [7:0]        sub;
    } st_t;

    st_t st_d, st_q;

    logic                        take;
    logic                        wipe;
    logic                        lba_ok, queue_ok, addr48;
    logic [UDMA_BITS-1:0]        udma_mask;
    logic [1:0]                  sec_kind, sec_flags;
    logic [3:0]                  sec_ratio;
    logic [C28_WORDS*WORD_W-1:0] cap28;
    logic [CAP_W-1:0]            cap48;
    reason_e                     rule_reason;
    logic [CAP_W-1:0]            rule_count;
    logic [MODE_W-1:0]           rule_mode;

    assign wipe = clear || start;
    assign take = st_q.armed && word_valid && !wipe;

    ident_capture #(
        .WORD_W(WORD_W), .IDX_W(IDX_W), .UDMA_BITS(UDMA_BITS),
        .C28_WORDS(C28_WORDS), .C48_WORDS(C48_WORDS)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe      (wipe),
        .take      (take),
        .idx       (word_idx),
        .data      (word_data),
        .lba_ok    (lba_ok),
        .queue_ok  (queue_ok),
        .addr48    (addr48),
        .udma_mask (udma_mask),
        .sec_kind  (sec_kind),
        .sec_flags (sec_flags),
        .sec_ratio (sec_ratio),
        .cap28     (cap28),
        .cap48     (cap48)
    );

    ident_rules #(
        .WORD_W(WORD_W), .UDMA_BITS(UDMA_BITS),
        .C28_WORDS(C28_WORDS), .C48_WORDS(C48_WORDS)
    ) u_rules (
        .pkt       (st_q.pkt),
        .lba_ok    (lba_ok),
        .queue_ok  (queue_ok),
        .addr48    (addr48),
        .udma_mask (udma_mask),
        .sec_kind  (sec_kind),
        .sec_flags (sec_flags),
        .sec_ratio (sec_ratio),
        .cap28     (cap28),
        .cap48     (cap48),
        .reason    (rule_reason),
        .count     (rule_count),
        .mode      (rule_mode)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clear) begin
            st_d = '0;
        end else if (start) begin
            st_d       = '0;
            st_d.armed = 1'b1;
            st_d.pkt   = is_packet;
        end else if (take && (word_idx == IDX_W'(LAST_IDX))) begin
            st_d.armed  = 1'b0;
            st_d.done   = 1'b1;
            st_d.reason = rule_reason;
            if (rule_reason == RSN_OK) begin
                st_d.accept = 1'b1;
                st_d.bsize  = SIZE_W'(BLOCK_BYTES);
                st_d.count  = rule_count;
                st_d.mode   = rule_mode;
                st_d.mbyte  = UDMA_BASE | 8'(rule_mode);
                st_d.op     = SF_OPCODE;
                st_d.sub    = SF_XFER;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy        = st_q.armed;
    assign done        = st_q.done;
    assign accept      = st_q.accept;
    assign reason      = st_q.reason;
    assign block_size  = st_q.bsize;
    assign block_count = st_q.count;
    assign udma_mode   = st_q.mode;
    assign mode_byte   = st_q.mbyte;
    assign sf_opcode   = st_q.op;
    assign sf_subcmd   = st_q.sub;

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!busy && !done && !accept && reason == 3'd0)); // R1
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R2
    AST_ACCEPT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (accept == (reason == 3'd0))); // R11
    AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !accept) |-> (block_count == '0 && mode_byte == 8'd0 && block_size == '0)); // R11
    AST_PACKET_GEOM: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accept && st_q.pkt) |-> (block_count == '0 && block_size == SIZE_W'(BLOCK_BYTES))); // R8
    AST_MODE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accept) |-> (mode_byte[7:3] == 5'b01000 && sf_opcode == 8'hEF)); // R10

endmodule

// File: tb/ata_ident_parser_test.sv
`timescale 1ns/1ps
module ata_ident_parser_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, clear = 1'b0, is_packet = 1'b0;
    logic        word_valid = 1'b0;
    logic [7:0]  word_idx = '0;
    logic [15:0] word_data = '0;
    logic        busy, done, accept;
    logic [2:0]  reason;
    logic [15:0] block_size;
    logic [63:0] block_count;
    logic [2:0]  udma_mode;
    logic [7:0]  mode_byte, sf_opcode, sf_subcmd;

    int checks = 0;
    int errors = 0;
    logic [15:0] img [256];

    always #2.5 clk = ~clk;

    ata_ident_parser uut (
        .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
        .is_packet(is_packet), .word_valid(word_valid), .word_idx(word_idx),
        .word_data(word_data), .busy(busy), .done(done), .accept(accept),
        .reason(reason), .block_size(block_size), .block_count(block_count),
        .udma_mode(udma_mode), .mode_byte(mode_byte), .sf_opcode(sf_opcode),
        .sf_subcmd(sf_subcmd)
    );

    typedef struct {
        logic        acc;
        logic [2:0]  rsn;
        logic [15:0] bs;
        logic [63:0] cnt;
        logic [2:0]  md;
        logic [7:0]  mb;
    } exp_t;

    function automatic exp_t model(input bit pkt);
        exp_t e;
        logic [15:0] s = img[106];
        logic [6:0]  m = img[88][6:0];
        logic [2:0]  hi = 3'd0;
        e = '{acc: 1'b0, rsn: 3'd0, bs: 16'd0, cnt: 64'd0, md: 3'd0, mb: 8'd0};
        for (int i = 0; i < 7; i++) if (m[i]) hi = 3'(i);
        if (!img[76][8]) e.rsn = 3'd1;
        else if (s[15:14] == 2'b01 && (s[8] || (s[9] && s[3:0] != 4'd0))) e.rsn = 3'd2;
        else if (!pkt && !img[49][9]) e.rsn = 3'd3;
        else if (m == 7'd0) e.rsn = 3'd4;
        if (e.rsn == 3'd0) begin
            e.acc = 1'b1;
            e.bs  = 16'd512;
            e.md  = hi;
            e.mb  = 8'h40 | 8'(hi);
            if (pkt) e.cnt = 64'd0;
            else if (img[83][10]) e.cnt = {img[103], img[102], img[101], img[100]};
            else e.cnt = {32'd0, img[61], img[60]};
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic good_img();
        for (int i = 0; i < 256; i++) img[i] = 16'($urandom);
        img[76]  = img[76] | 16'h0100;
        img[49]  = img[49] | 16'h0200;
        img[106] = 16'h4000;
        img[88]  = 16'h001F;
    endtask

    task automatic open_session(input bit pkt);
        @(negedge clk);
        start = 1'b1; is_packet = pkt;
        @(negedge clk);
        start = 1'b0; is_packet = 1'b0;
    endtask

    // streams all words; if dup, index 88 first carries early and is resent later
    task automatic stream(input int gap, input bit dup, input logic [15:0] early);
        for (int i = 0; i < 256; i++) begin
            if (gap > 0 && ($urandom % 4) == 0) begin
                word_valid = 1'b0;
                repeat (1 + $urandom % gap) @(negedge clk);
            end
            word_valid = 1'b1;
            word_idx   = 8'(i);
            word_data  = (dup && i == 88) ? early : img[i];
            @(negedge clk);
            if (dup && i == 100) begin
                word_idx = 8'd88; word_data = img[88];
                @(negedge clk);
            end
        end
        word_valid = 1'b0;
    endtask

    task automatic check_result(input string tag, input exp_t e);
        chk(done === 1'b1, {tag, " R2 done"}, 64'(done), 64'd1);
        chk(reason === e.rsn, {tag, " R11 reason"}, 64'(reason), 64'(e.rsn));
        chk(accept === e.acc, {tag, " R11 accept"}, 64'(accept), 64'(e.acc));
        chk(block_size === e.bs, {tag, " R8 size"}, 64'(block_size), 64'(e.bs));
        chk(block_count === e.cnt, {tag, " R6/R7 count"}, block_count, e.cnt);
        chk(udma_mode === e.md, {tag, " R9 mode"}, 64'(udma_mode), 64'(e.md));
        chk(mode_byte === e.mb, {tag, " R10 byte"}, 64'(mode_byte), 64'(e.mb));
        chk(sf_opcode === (e.acc ? 8'hEF : 8'h00), {tag, " R10 opcode"}, 64'(sf_opcode), 64'(e.acc ? 8'hEF : 8'h00));
        chk(sf_subcmd === (e.acc ? 8'h03 : 8'h00), {tag, " R10 subcmd"}, 64'(sf_subcmd), 64'(e.acc ? 8'h03 : 8'h00));
        @(negedge clk);
        chk(done === 1'b0, {tag, " R2 pulse width"}, 64'(done), 64'd0);
        chk(reason === e.rsn && block_count === e.cnt, {tag, " R2 hold"}, block_count, e.cnt);
    endtask

    task automatic run_case(input string tag, input bit pkt, input int gap);
        exp_t e;
        e = model(pkt);
        open_session(pkt);
        stream(gap, 1'b0, 16'h0);
        check_result(tag, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_t e;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !accept && reason == 0 && block_count == 0 && mode_byte == 0,
            "R1 reset state", 64'({busy, done, accept, reason}), 64'd0);

        good_img(); img[83] = 16'h0400; run_case("R7 48-bit", 1'b0, 0);
        good_img(); img[83] = 16'h0000; run_case("R6 28-bit", 1'b0, 2);
        good_img(); img[76] = 16'h0000; img[88] = 16'h0000; run_case("R3 no queue, R11 priority", 1'b0, 0);
        good_img(); img[106] = 16'h4100; run_case("R4 bit8", 1'b0, 0);
        good_img(); img[106] = 16'h4203; run_case("R4 bit9 ratio", 1'b0, 0);
        good_img(); img[106] = 16'h4200; run_case("R4 bit9 zero ratio", 1'b0, 0);
        good_img(); img[106] = 16'hC100; run_case("R4 no signature", 1'b0, 0);
        good_img(); img[49] = 16'h0000; run_case("R5 no lba", 1'b0, 0);
        good_img(); img[49] = 16'h0000; run_case("R5 R8 packet exempt", 1'b1, 0);
        good_img(); img[88] = 16'hFF00; run_case("R9 zero mask", 1'b0, 0);
        good_img(); img[88] = 16'h007F; run_case("R9 R10 full mask", 1'b0, 0);
        good_img(); img[88] = 16'h0081; run_case("R9 bit7 ignored", 1'b0, 0);

        // R12 duplicate word: later value wins
        good_img(); img[88] = 16'h0004;
        e = model(1'b0);
        open_session(1'b0);
        stream(0, 1'b1, 16'h0040);
        check_result("R12 duplicate", e);

        // R2 words outside a session are ignored
        good_img(); img[76] = 16'h0000;
        stream(0, 1'b0, 16'h0);
        chk(done === 1'b0 && reason === e.rsn && block_count === e.cnt,
            "R2 no session", 64'({done, reason}), 64'(e.rsn));

        // R1 R2 clear mid-session
        good_img();
        open_session(1'b0);
        for (int i = 0; i < 40; i++) begin
            word_valid = 1'b1; word_idx = 8'(i); word_data = img[i];
            @(negedge clk);
        end
        word_valid = 1'b0; clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        chk(!busy && !accept && reason == 0 && block_count == 0 && mode_byte == 0,
            "R1 after clear", 64'({busy, accept, reason}), 64'd0);
        stream(0, 1'b0, 16'h0);
        chk(done === 1'b0 && !busy, "R2 cleared session", 64'(done), 64'd0);

        // random mix
        for (int n = 0; n < 40; n++) begin
            good_img();
            if ($urandom % 5 == 0) img[76] = 16'($urandom) & 16'hFEFF;
            if ($urandom % 4 == 0) img[106] = 16'($urandom);
            if ($urandom % 5 == 0) img[49] = 16'($urandom) & 16'hFDFF;
            if ($urandom % 3 == 0) img[88] = 16'($urandom);
            if ($urandom % 6 == 0) img[88] = 16'($urandom) & 16'hFF80;
            run_case("random R3 R4 R5 R6 R7 R9", 1'($urandom % 4 == 0), 3);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule